// File: doc/BRIEF.md
# On-the-Fly Signed-Digit Quotient Converter

This block accepts a stream of radix-2 quotient digits drawn from {-1, 0, +1}, most significant digit first, and builds the ordinary two's complement quotient while the digits arrive. No carry-propagate adder is involved. Two candidate registers are kept side by side. The primary candidate holds the exact binary value of the digits received so far. The companion candidate holds that value minus one unit in the last place. Each accepted digit rebuilds both candidates by choosing one of the two previous values, shifting it left by one place and appending a single bit. The final quotient is therefore ready in the cycle right after the last digit is taken.

A digit-recurrence divider sits upstream. It clears the converter at the start of each division and then presents one digit per valid cycle. When the block has accepted `N` digits it raises `done` and freezes. The result is the signed integer Q·2^N, where Q = Σ q_j·2^-j. The companion output, equal to result minus one, is offered to downstream logic that has to correct the quotient by one unit when the final remainder turns out negative.

A small sequencer with three states tracks progress:
- `ST_EMPTY`: cleared, no digit taken yet.
- `ST_FILL`: at least one digit taken, fewer than `N`.
- `ST_FULL`: `N` digits taken; the result is final.

Its transitions are:
- `T_START`: `ST_EMPTY` to `ST_FILL` on the first accepted digit.
- `T_STEP`: stay in `ST_FILL` on an accepted digit that is not the last.
- `T_LAST`: `ST_EMPTY` or `ST_FILL` to `ST_FULL` on the `N`-th accepted digit.
- `T_CLEAR`: any state to `ST_EMPTY` on `clr`.

Top module: `otf_quot_conv`

## Requirements
- R1: After reset or after a cycle with `clr` high, `result` is 0, `res_lo` is all ones (-1) and `done` is 0.
- R2: Digit code `dig` = 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. After `N` accepted digits q_1..q_N, `result` equals the (N+1)-bit two's complement integer Σ q_j·2^(N-j).
- R3: The cycle after an accepted digit q, `result` equals twice its previous value plus q, in (N+1)-bit two's complement.
- R4: `done` stays 0 until the `N`-th digit is accepted. It is 1 in the cycle right after that digit, and `result` is already final in that same cycle.
- R5: While `done` is 1 and `clr` is low, further digits are ignored: `result`, `res_lo` and `done` hold.
- R6: Code 2'b10 is reserved. A valid cycle carrying it is rejected: it changes no output and does not count toward the `N` digits.
- R7: A cycle with `dig_vld` low changes no output.
- R8: When `clr` and `dig_vld` are both high in one cycle, the clear wins and the digit is dropped.
- R9: `res_lo` always equals `result` minus 1, modulo 2^(N+1).
- R10: The extreme strings convert without overflow: all +1 gives 2^N-1, and all -1 gives -(2^N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; starts a new quotient |
| dig_vld | input | 1 | Digit on `dig` is presented this cycle |
| dig | input | 2 | Signed digit code: 01 = +1, 00 = 0, 11 = -1, 10 reserved |
| done | output | 1 | `N` digits accepted; result final |
| result | output | N+1 | Converted quotient, two's complement, value Q·2^N |
| res_lo | output | N+1 | Converted quotient minus one unit in the last place |

## Verification
The conversion is driven with four fixed digit strings and many random ones. All +1 and all -1 reach the positive and negative extremes, which exposes overflow and sign-fill faults. All zeros keeps the primary candidate idle while the companion fills with ones. Alternating +1/-1 forces a cross-select between the two candidates on every digit. Random strings with idle gaps and reserved codes scattered through them confirm that only legal valid digits are counted. Each intermediate value is compared with the doubled-plus-digit recurrence, and each final value is compared through a scoreboard when `done` rises.

// File: rtl/otf_pkg.sv
package otf_pkg;

    // Signed-digit encoding on the dig port
    typedef enum logic [1:0] {
        DG_ZERO  = 2'b00,
        DG_PLUS  = 2'b01,
        DG_RSVD  = 2'b10,
        DG_MINUS = 2'b11
    } digit_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_FILL  = 2'b01,
        ST_FULL  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/otf_digit_dec.sv
module otf_digit_dec
    import otf_pkg::*;
(
    input  logic [1:0] code,
    output logic       is_pos,
    output logic       is_neg,
    output logic       is_zero,
    output logic       legal
);

    always_comb begin
        is_pos  = 1'b0;
        is_neg  = 1'b0;
        is_zero = 1'b0;
        legal   = 1'b1;
        unique case (digit_e'(code))
            DG_PLUS:  is_pos  = 1'b1;
            DG_MINUS: is_neg  = 1'b1;
            DG_ZERO:  is_zero = 1'b1;
            DG_RSVD:  legal   = 1'b0;
            default:  legal   = 1'b0;
        endcase
    end

endmodule

// File: rtl/otf_seq.sv
module otf_seq
    import otf_pkg::*;
#(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dig_vld,
    input  logic legal,
    output logic adv,
    output logic done
);

    localparam int CW = $clog2(N + 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic take;
    logic last;

    // Digit qualification and last-digit detection
    always_comb begin
        take = dig_vld && legal && !clr && (state_q != ST_FULL);
        last = (cnt_q == CW'(N - 1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = ST_EMPTY;             // T_CLEAR
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (take) begin
                        state_d = last ? ST_FULL : ST_FILL;  // T_LAST / T_START
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
                ST_FILL: begin
                    if (take) begin
                        state_d = last ? ST_FULL : ST_FILL;  // T_LAST / T_STEP
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
                ST_FULL: begin
                    state_d = ST_FULL;
                end
                default: begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        adv  = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_EMPTY: adv = take;
            ST_FILL:  adv = take;
            ST_FULL:  done = 1'b1;
            default: begin
                adv  = 1'b0;
                done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/otf_lane.sv
module otf_lane #(
    parameter int W         = 17,
    parameter bit INIT_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] src_keep,
    input  logic [W-1:0] src_alt,
    input  logic         use_alt,
    input  logic         app_bit,
    output logic [W-1:0] z
);

    localparam logic [W-1:0] INIT_VAL = INIT_ONES ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] picked;
    logic [W-1:0] next_z;

    always_comb begin
        picked = use_alt ? src_alt : src_keep;
        next_z = {picked[W-2:0], app_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z <= INIT_VAL;
        end else if (clr) begin
            z <= INIT_VAL;
        end else if (adv) begin
            z <= next_z;
        end
    end

endmodule

// File: rtl/otf_quot_conv.sv
module otf_quot_conv
    import otf_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         dig_vld,
    input  logic [1:0]   dig,
    output logic         done,
    output logic [N:0]   result,
    output logic [N:0]   res_lo
);

    localparam int W  = N + 1;
    localparam int NL = 2;      // lane 0: exact value, lane 1: value minus one ulp

    logic is_pos, is_neg, is_zero, legal;
    logic adv;
    logic [W-1:0] z_lane [NL];

    otf_digit_dec u_dec (
        .code    (dig),
        .is_pos  (is_pos),
        .is_neg  (is_neg),
        .is_zero (is_zero),
        .legal   (legal)
    );

    otf_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .dig_vld (dig_vld),
        .legal   (legal),
        .adv     (adv),
        .done    (done)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lane
        if (g == 0) begin : g_exact
            // -1: take lower candidate, append 1; 0: keep, append 0; +1: keep, append 1
            otf_lane #(.W(W), .INIT_ONES(1'b0)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr),
                .adv      (adv),
                .src_keep (z_lane[0]),
                .src_alt  (z_lane[1]),
                .use_alt  (is_neg),
                .app_bit  (is_pos | is_neg),
                .z        (z_lane[g])
            );
        end else begin : g_lower
            // -1: keep, append 0; 0: keep, append 1; +1: take exact candidate, append 0
            otf_lane #(.W(W), .INIT_ONES(1'b1)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr),
                .adv      (adv),
                .src_keep (z_lane[1]),
                .src_alt  (z_lane[0]),
                .use_alt  (is_pos),
                .app_bit  (is_zero),
                .z        (z_lane[g])
            );
        end
    end

    assign result = z_lane[0];
    assign res_lo = z_lane[1];

endmodule

// File: rtl/otf_quot_conv_chk.sv
module otf_quot_conv_chk #(
    parameter int N = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       dig_vld,
    input logic [1:0] dig,
    input logic       done,
    input logic [N:0] result,
    input logic [N:0] res_lo
);

    localparam int W  = N + 1;
    localparam int CW = $clog2(N + 2);

    logic take;
    logic [CW-1:0] acc_cnt;

    assign take = dig_vld && !clr && !done && (dig != 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc_cnt <= '0;
        else if (clr)  acc_cnt <= '0;
        else if (take) acc_cnt <= acc_cnt + CW'(1);
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (result == '0) && (res_lo == '1) && !done);  // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && dig_vld) |=> (result == '0) && !done);  // R8

    AST_STEP_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dig == 2'b01) |=> result == {$past(result[W-2:0]), 1'b1});  // R3

    AST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dig == 2'b00) |=> result == {$past(result[W-2:0]), 1'b0});  // R3

    AST_STEP_MINUS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dig == 2'b11) |=> result == ({$past(result[W-2:0]), 1'b0} - W'(1)));  // R3

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> acc_cnt == CW'(N));  // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done && $stable(result) && $stable(res_lo));  // R5

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_vld && dig == 2'b10 && !clr) |=> $stable(result) && $stable(done));  // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dig_vld && !clr) |=> $stable(result) && $stable(res_lo) && $stable(done));  // R7

    AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        W'(result - res_lo) == W'(1));  // R9

endmodule

bind otf_quot_conv otf_quot_conv_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .dig_vld (dig_vld),
    .dig     (dig),
    .done    (done),
    .result  (result),
    .res_lo  (res_lo)
);

// File: tb/test_otf_quot_conv.sv
module test_otf_quot_conv;

    localparam int N = 16;
    localparam int W = N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         dig_vld = 1'b0;
    logic [1:0]   dig = 2'b00;
    logic         done;
    logic [W-1:0] result;
    logic [W-1:0] res_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit seen_done = 0;
    logic [W-1:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    otf_quot_conv #(.N(N)) i_otf_quot_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .dig_vld (dig_vld),
        .dig     (dig),
        .done    (done),
        .result  (result),
        .res_lo  (res_lo)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle starting at a negedge; returns at the next negedge
    task automatic cyc(input logic v, input logic [1:0] c, input logic cl);
        dig_vld = v;
        dig     = c;
        clr     = cl;
        @(negedge clk);
        dig_vld = 1'b0;
        clr     = 1'b0;
    endtask

    function automatic int code_val(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    // mode: 0 random, 1 all +1, 2 all -1, 3 all 0, 4 alternating
    task automatic run_string(input int mode, input bit noisy);
        logic [1:0] codes [N];
        longint e = 0;
        for (int i = 0; i < N; i++) begin
            int r;
            case (mode)
                1: codes[i] = 2'b01;
                2: codes[i] = 2'b11;
                3: codes[i] = 2'b00;
                4: codes[i] = (i % 2 == 0) ? 2'b01 : 2'b11;
                default: begin
                    r = $urandom_range(0, 2);
                    codes[i] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
                end
            endcase
            e = 2 * e + code_val(codes[i]);
        end
        exp_q.push_back(W'(e));
        cyc(1'b0, 2'b00, 1'b1);
        chk("R1 clear result", result, '0);
        chk("R1 clear res_lo", res_lo, '1);
        chk("R1 clear done", {{(W-1){1'b0}}, done}, '0);
        e = 0;
        for (int i = 0; i < N; i++) begin
            if (noisy && $urandom_range(0, 3) == 0) begin
                cyc(1'b0, 2'b01, 1'b0);
                chk("R7 idle hold", result, W'(e));
            end
            if (noisy && $urandom_range(0, 4) == 0) begin
                cyc(1'b1, 2'b10, 1'b0);
                chk("R6 reserved hold", result, W'(e));
                chk("R6 reserved done", {{(W-1){1'b0}}, done}, '0);
            end
            cyc(1'b1, codes[i], 1'b0);
            e = 2 * e + code_val(codes[i]);
            chk("R3 step", result, W'(e));
            chk("R9 lower", res_lo, W'(e - 1));
            chk("R4 done timing", {{(W-1){1'b0}}, done}, (i == N - 1) ? W'(1) : W'(0));
        end
    endtask

    // Scoreboard monitor: compares final value when done rises
    always @(negedge clk) begin
        if (!done) begin
            seen_done = 0;
        end else if (!seen_done) begin
            seen_done = 1;
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R4 unexpected done: got 1 expected 0");
            end else begin
                logic [W-1:0] x;
                x = exp_q.pop_front();
                chk("R2 final result", result, x);
                chk("R9 final res_lo", res_lo, W'(x - W'(1)));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset result", result, '0);
        chk("R1 reset res_lo", res_lo, '1);
        chk("R1 reset done", {{(W-1){1'b0}}, done}, '0);

        run_string(1, 0);   // R10 all +1
        chk("R10 max", result, W'((1 << N) - 1));
        run_string(2, 0);   // R10 all -1
        chk("R10 min", result, W'(-((1 << N) - 1)));
        run_string(3, 0);
        run_string(4, 0);

        // R5: digits after done are ignored
        held = result;
        cyc(1'b1, 2'b11, 1'b0);
        cyc(1'b1, 2'b01, 1'b0);
        chk("R5 hold result", result, held);
        chk("R5 hold res_lo", res_lo, W'(held - W'(1)));
        chk("R5 hold done", {{(W-1){1'b0}}, done}, W'(1));

        // R8: clear wins over a digit in the same cycle
        cyc(1'b1, 2'b01, 1'b1);
        chk("R8 clear wins result", result, '0);
        chk("R8 clear wins done", {{(W-1){1'b0}}, done}, '0);
        cyc(1'b1, 2'b01, 1'b0);
        chk("R8 next digit", result, W'(1));

        // R1: clear in the middle of a string
        cyc(1'b1, 2'b11, 1'b0);
        cyc(1'b0, 2'b00, 1'b1);
        chk("R1 mid clear", result, '0);

        for (int k = 0; k < 30; k++) run_string(0, 1);

        cyc(1'b0, 2'b00, 1'b0);
        chk("R2 scoreboard drained", W'(exp_q.size()), '0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule